// File: doc/BRIEF.md
# Accumulator Machine Instruction Executor

This block runs one instruction at a time for a 16-bit accumulator machine. The machine also has a one-bit link register and an 11-bit program counter. A start pulse loads the program counter, the accumulator and the link from the block's inputs. The block then fetches the word at the program counter from a synchronous single-port memory and executes it. When the instruction is finished it raises a one-clock done pulse and reports the machine cycles the instruction is charged with.

The instruction set covers several groups:
- two immediate loads
- the jump and the subroutine call
- store, exchange, and increment-and-skip
- the logical operations AND, OR and XOR, and load
- add and subtract
- compare-and-skip

Every memory-reference instruction may go through one level of indirection. A pointer held in the auto-index window (locations 010 to 017) is incremented in memory before it is used. The memory port is used at most once per clock, so one machine cycle takes several clocks.

Top module: `acc_exec_unit`

## Requirements
- R1: A `start` pulse while idle loads PC from `start_pc`, AC from `ac_init` and L from `link_init`. While idle with no start, PC, AC and L hold their values.
- R2: The instruction word is split into three fields. Bits 15:12 are the opcode: 0 immediate load, 1 complemented immediate load, 2 jump, 3 call, 4 store, 5 exchange, 6 increment-and-skip, 7 AND, 8 OR, 9 XOR, 10 load, 11 add, 12 subtract, 13 skip-if-equal. Bit 11 is the indirect flag and bits 10:0 are the address. Opcodes 14 and 15 change nothing except PC+1 and are charged 1 cycle.
- R3: Each instruction ends with a done pulse exactly one clock wide, and `cycles` is valid with it. Immediate and unused opcodes report 1, direct memory references report 2 and indirect ones report 3.
- R4: Opcode 0 loads AC with the low 8 bits of the word, zero-extended. Opcode 1 loads AC with the bitwise complement of that value, so field 1 gives 0177776. Neither opcode changes L.
- R5: For an indirect reference whose pointer location is in 010..017, the pointer plus one is written back to that location and its low 11 bits become the effective address. For a pointer anywhere else, the pointer is used unchanged and memory is not written.
- R6: A jump sets PC to the effective address. A call writes PC+1 (zero-extended) to the effective address and sets PC to the effective address plus one.
- R7: A store writes AC to the effective address. An exchange writes AC there and loads AC with the word that was there before.
- R8: Increment-and-skip writes the word plus one (mod 2^16) back. PC advances by 2 if the written value is 0 and by 1 otherwise.
- R9: AND, OR, XOR and load replace AC with their result and leave L unchanged.
- R10: Add and subtract wrap AC modulo 2^16. L is inverted when the add carries out of bit 15 or the subtract borrows, and is otherwise unchanged.
- R11: Skip-if-equal advances PC by 2 when AC equals the operand and by 1 otherwise, and leaves AC and L unchanged.
- R12: The memory port never asserts read and write in the same clock. Read data is taken on the clock after the read strobe.
- R13: PC is 11 bits wide and wraps from 03777 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one instruction (taken only while idle) |
| start_pc | input | 11 | Address of the instruction to run |
| ac_init | input | 16 | Accumulator value loaded at start |
| link_init | input | 1 | Link value loaded at start |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 11 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one clock after `mem_rd` |
| pc | output | 11 | Program counter |
| ac | output | 16 | Accumulator |
| link | output | 1 | Link bit |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-clock pulse at the end of an instruction |
| cycles | output | 2 | Machine cycles used by the finished instruction |

## Verification
The bench targets the auto-index window. A jump through 010 must land one past the stored pointer and leave the pointer incremented, while a pointer at 0110 must stay untouched; a design that ignored the window would land on 0120, and one that widened it would corrupt ordinary pointers. The bench also checks link toggling against link loading: an add of 1 and 0177777 with L already 1 must clear L, which a loading design would get wrong. Increment-and-skip is checked at the 0177777 to 0 boundary and one step before it, the immediate complement load and PC wrap at 03777 are exercised, and an unused opcode must leave AC alone and report one cycle.

// File: rtl/acc_exec_pkg.sv
// Shared opcode and sequencer state encodings for the accumulator executor.
// Assumes a 4-bit opcode field at the top of each instruction word.
package acc_exec_pkg;

    typedef enum logic [3:0] {
        OP_LDI    = 4'd0,
        OP_LDC    = 4'd1,
        OP_JMP    = 4'd2,
        OP_CALL   = 4'd3,
        OP_STORE  = 4'd4,
        OP_SWAP   = 4'd5,
        OP_INCSKP = 4'd6,
        OP_AND    = 4'd7,
        OP_OR     = 4'd8,
        OP_XOR    = 4'd9,
        OP_LOAD   = 4'd10,
        OP_ADD    = 4'd11,
        OP_SUB    = 4'd12,
        OP_SKEQ   = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_POINTER,
        ST_OPER,
        ST_EXEC
    } state_e;

    typedef struct packed {
        logic is_imm;     // immediate load, no memory operand
        logic is_memref;  // uses an effective address
        logic need_opnd;  // reads the word at the effective address
        logic is_nop;     // unused opcode
    } ctl_t;

endpackage

// File: rtl/acc_exec_decode.sv
// Instruction field splitter and class decoder.
// Assumes: opcode in the top 4 bits, indirect flag below it, address in the rest.
module acc_exec_decode
    import acc_exec_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int ADDR_W = WORD_W - 5
) (
    input  logic [WORD_W-1:0] ir,
    output opcode_e           op,
    output logic              ind,
    output logic [ADDR_W-1:0] addr,
    output ctl_t              ctl
);

    assign op   = opcode_e'(ir[WORD_W-1 -: 4]);
    assign ind  = ir[ADDR_W];
    assign addr = ir[ADDR_W-1:0];

    // Classify the opcode into the sequencing groups used by the controller.
    always_comb begin
        ctl = '0;
        unique case (op)
            OP_LDI, OP_LDC:               ctl.is_imm = 1'b1;
            OP_JMP, OP_CALL, OP_STORE:    ctl.is_memref = 1'b1;
            OP_RSV14, OP_RSV15:           ctl.is_nop = 1'b1;
            default: begin
                ctl.is_memref = 1'b1;
                ctl.need_opnd = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/acc_exec_ea.sv
// Effective-address former for indirect references.
// Assumes the pointer word has just been read from location ptr_loc.
module acc_exec_ea #(
    parameter int WORD_W     = 16,
    parameter int ADDR_W     = 11,
    parameter int AUTO_BASE  = 8,
    parameter int AUTO_COUNT = 8
) (
    input  logic [ADDR_W-1:0] ptr_loc,
    input  logic [WORD_W-1:0] ptr_word,
    output logic              auto_hit,
    output logic [WORD_W-1:0] ptr_next,
    output logic [ADDR_W-1:0] ea
);

    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(AUTO_BASE);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(AUTO_BASE + AUTO_COUNT);

    // Detect the auto-index window and pick the pointer or its successor.
    always_comb begin
        auto_hit = ({1'b0, ptr_loc} >= WIN_LO) && ({1'b0, ptr_loc} < WIN_HI);
        ptr_next = ptr_word + 1'b1;
        ea       = auto_hit ? ptr_next[ADDR_W-1:0] : ptr_word[ADDR_W-1:0];
    end

endmodule

// File: rtl/acc_exec_alu.sv
// Data path for operand-using instructions: logic, arithmetic and skips.
// Assumes opnd is the word read from the effective address.
module acc_exec_alu
    import acc_exec_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  opcode_e           op,
    input  logic [WORD_W-1:0] ac,
    input  logic              link,
    input  logic [WORD_W-1:0] opnd,
    output logic [WORD_W-1:0] ac_nx,
    output logic              link_nx,
    output logic [WORD_W-1:0] mem_nx,
    output logic              skip
);

    logic [WORD_W:0]   sum;
    logic [WORD_W:0]   diff;
    logic [WORD_W-1:0] inc;

    // Compute the new accumulator, link, write-back word and skip flag.
    always_comb begin
        sum     = {1'b0, ac} + {1'b0, opnd};
        diff    = {1'b0, ac} - {1'b0, opnd};
        inc     = opnd + 1'b1;
        ac_nx   = ac;
        link_nx = link;
        mem_nx  = ac;
        skip    = 1'b0;
        case (op)
            OP_SWAP:   ac_nx = opnd;
            OP_INCSKP: begin
                mem_nx = inc;
                skip   = (inc == '0);
            end
            OP_AND:    ac_nx = ac & opnd;
            OP_OR:     ac_nx = ac | opnd;
            OP_XOR:    ac_nx = ac ^ opnd;
            OP_LOAD:   ac_nx = opnd;
            OP_ADD: begin
                ac_nx   = sum[WORD_W-1:0];
                link_nx = link ^ sum[WORD_W];
            end
            OP_SUB: begin
                ac_nx   = diff[WORD_W-1:0];
                link_nx = link ^ diff[WORD_W];
            end
            OP_SKEQ:   skip = (ac == opnd);
            default:   ;
        endcase
    end

endmodule

// File: rtl/acc_exec_unit.sv
// Top: multi-clock sequencer executing one instruction per start pulse.
// Assumes a synchronous memory returning read data one clock after mem_rd.
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int IMM_W      = 8,
    parameter int AUTO_BASE  = 8,
    parameter int AUTO_COUNT = 8,
    localparam int ADDR_W    = WORD_W - 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_pc,
    input  logic [WORD_W-1:0] ac_init,
    input  logic              link_init,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] ac,
    output logic              link,
    output logic              busy,
    output logic              done,
    output logic [1:0]        cycles
);

    localparam logic [1:0] CYC_ONE = 2'd1;
    localparam logic [1:0] CYC_DIR = 2'd2;
    localparam logic [1:0] CYC_IND = 2'd3;

    state_e            state;
    logic [WORD_W-1:0] ir;
    logic [ADDR_W-1:0] ea;
    logic [WORD_W-1:0] ir_src;
    opcode_e           op;
    logic              ind;
    logic [ADDR_W-1:0] fld_addr;
    ctl_t              ctl;
    logic              auto_hit;
    logic [WORD_W-1:0] ptr_next;
    logic [ADDR_W-1:0] ea_ind;
    logic [WORD_W-1:0] alu_ac;
    logic              alu_link;
    logic [WORD_W-1:0] alu_mem;
    logic              alu_skip;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] ea_inc;
    logic [WORD_W-1:0] imm_val;
    logic [1:0]        mem_cyc;

    // Decode straight from memory in the decode clock, from the held word after.
    assign ir_src  = (state == ST_DECODE) ? mem_rdata : ir;
    assign pc_inc  = pc + 1'b1;
    assign ea_inc  = ea + 1'b1;
    assign imm_val = {{(WORD_W-IMM_W){1'b0}}, ir_src[IMM_W-1:0]};
    assign mem_cyc = ind ? CYC_IND : CYC_DIR;
    assign busy    = (state != ST_IDLE);

    acc_exec_decode #(.WORD_W(WORD_W)) u_dec (
        .ir   (ir_src),
        .op   (op),
        .ind  (ind),
        .addr (fld_addr),
        .ctl  (ctl)
    );

    acc_exec_ea #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .AUTO_BASE (AUTO_BASE),
        .AUTO_COUNT(AUTO_COUNT)
    ) u_ea (
        .ptr_loc  (fld_addr),
        .ptr_word (mem_rdata),
        .auto_hit (auto_hit),
        .ptr_next (ptr_next),
        .ea       (ea_ind)
    );

    acc_exec_alu #(.WORD_W(WORD_W)) u_alu (
        .op      (op),
        .ac      (ac),
        .link    (link),
        .opnd    (mem_rdata),
        .ac_nx   (alu_ac),
        .link_nx (alu_link),
        .mem_nx  (alu_mem),
        .skip    (alu_skip)
    );

    // Drive the single memory port from the current state.
    always_comb begin
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc;
        mem_wdata = '0;
        case (state)
            ST_FETCH: mem_rd = 1'b1;
            ST_DECODE: begin
                if (ctl.is_memref && ind) begin
                    mem_rd   = 1'b1;
                    mem_addr = fld_addr;
                end
            end
            ST_POINTER: begin
                if (auto_hit) begin
                    mem_we    = 1'b1;
                    mem_addr  = fld_addr;
                    mem_wdata = ptr_next;
                end
            end
            ST_OPER: begin
                mem_addr = ea;
                if (op == OP_CALL) begin
                    mem_we    = 1'b1;
                    mem_wdata = {{(WORD_W-ADDR_W){1'b0}}, pc_inc};
                end else if (op == OP_STORE) begin
                    mem_we    = 1'b1;
                    mem_wdata = ac;
                end else if (ctl.need_opnd) begin
                    mem_rd = 1'b1;
                end
            end
            ST_EXEC: begin
                mem_addr = ea;
                if (op == OP_SWAP || op == OP_INCSKP) begin
                    mem_we    = 1'b1;
                    mem_wdata = alu_mem;
                end
            end
            default: ;
        endcase
    end

    // Sequence the instruction and update the architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ir     <= '0;
            ea     <= '0;
            pc     <= '0;
            ac     <= '0;
            link   <= 1'b0;
            done   <= 1'b0;
            cycles <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc    <= start_pc;
                        ac    <= ac_init;
                        link  <= link_init;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: state <= ST_DECODE;
                ST_DECODE: begin
                    ir <= mem_rdata;
                    if (ctl.is_imm || ctl.is_nop) begin
                        if (op == OP_LDI) ac <= imm_val;
                        if (op == OP_LDC) ac <= ~imm_val;
                        pc     <= pc_inc;
                        done   <= 1'b1;
                        cycles <= CYC_ONE;
                        state  <= ST_IDLE;
                    end else if (ind) begin
                        state <= ST_POINTER;
                    end else begin
                        ea    <= fld_addr;
                        state <= ST_OPER;
                    end
                end
                ST_POINTER: begin
                    ea    <= ea_ind;
                    state <= ST_OPER;
                end
                ST_OPER: begin
                    if (ctl.need_opnd) begin
                        state <= ST_EXEC;
                    end else begin
                        if (op == OP_JMP)       pc <= ea;
                        else if (op == OP_CALL) pc <= ea_inc;
                        else                    pc <= pc_inc;
                        done   <= 1'b1;
                        cycles <= mem_cyc;
                        state  <= ST_IDLE;
                    end
                end
                ST_EXEC: begin
                    ac     <= alu_ac;
                    link   <= alu_link;
                    pc     <= alu_skip ? pc + 2'd2 : pc_inc;
                    done   <= 1'b1;
                    cycles <= mem_cyc;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/acc_exec_chk.sv
// Protocol checker for the executor's ports, attached by bind below.
// Assumes the synchronous active-low reset of the checked block.
module acc_exec_chk #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_pc,
    input logic [WORD_W-1:0] ac_init,
    input logic              link_init,
    input logic              mem_rd,
    input logic              mem_we,
    input logic [ADDR_W-1:0] pc,
    input logic [WORD_W-1:0] ac,
    input logic              link,
    input logic              busy,
    input logic              done,
    input logic [1:0]        cycles
);

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we)); // R12
    AST_CYCLES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles != 2'd0)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && pc == $past(start_pc) && ac == $past(ac_init)
                              && link == $past(link_init))); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(pc) && $stable(ac) && $stable(link))); // R1

endmodule

bind acc_exec_unit acc_exec_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_pc  (start_pc),
    .ac_init   (ac_init),
    .link_init (link_init),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .pc        (pc),
    .ac        (ac),
    .link      (link),
    .busy      (busy),
    .done      (done),
    .cycles    (cycles)
);

// File: tb/sim_acc_exec_unit.sv
// Scoreboard bench: the driver queues expected end states, the monitor
// compares them when done pulses.
module sim_acc_exec_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] ac;
        logic        link;
        logic [10:0] pc;
        logic [1:0]  cyc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [10:0] start_pc = '0;
    logic [15:0] ac_init = '0;
    logic        link_init = 1'b0;
    logic        mem_rd, mem_we;
    logic [10:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [10:0] pc;
    logic [15:0] ac;
    logic        link, busy, done;
    logic [1:0]  cycles;

    logic [15:0] mem [0:2047];
    logic        tb_we = 1'b0;
    logic [10:0] tb_a = '0;
    logic [15:0] tb_d = '0;

    exp_t q[$];
    int mon_checks = 0, mon_errors = 0;
    int drv_checks = 0, drv_errors = 0;
    int clash = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
        .ac_init(ac_init), .link_init(link_init), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pc(pc), .ac(ac), .link(link),
        .busy(busy), .done(done), .cycles(cycles)
    );

    // Synchronous memory model with a bench preload path.
    always @(posedge clk) begin
        if (tb_we) mem[tb_a] <= tb_d;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // Monitor: pop expectations on done and compare.
    always @(negedge clk) begin
        if (rst_n && mem_rd && mem_we) clash++;
        if (rst_n && done) begin
            if (q.size() == 0) begin
                mon_checks++; mon_errors++;
                $display("FAIL R3 unexpected done actual 1 expected 0");
            end else begin
                exp_t e;
                e = q.pop_front();
                mon_checks += 4;
                if (ac !== e.ac) begin
                    mon_errors++;
                    $display("FAIL %s ac actual %0o expected %0o", e.tag, ac, e.ac);
                end
                if (link !== e.link) begin
                    mon_errors++;
                    $display("FAIL %s link actual %0d expected %0d", e.tag, link, e.link);
                end
                if (pc !== e.pc) begin
                    mon_errors++;
                    $display("FAIL %s pc actual %0o expected %0o", e.tag, pc, e.pc);
                end
                if (cycles !== e.cyc) begin
                    mon_errors++;
                    $display("FAIL %s R3 cycles actual %0d expected %0d", e.tag, cycles, e.cyc);
                end
            end
        end
    end

    function automatic logic [15:0] enc(input int op, input bit ind, input logic [10:0] a);
        return {op[3:0], ind, a};
    endfunction

    task automatic poke(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_a = a; tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        drv_checks++;
        if (!ok) begin
            drv_errors++;
            $display("FAIL %s actual %0o expected %0o", tag, act, exp);
        end
    endtask

    task automatic memchk(input logic [10:0] a, input logic [15:0] exp, input string tag);
        chk(mem[a] === exp, tag, mem[a], exp);
    endtask

    // Driver: queue the expected end state, then pulse start and wait.
    task automatic run(input logic [10:0] p0, input logic [15:0] a0, input logic l0,
                       input logic [15:0] eac, input logic el, input logic [10:0] epc,
                       input logic [1:0] ecyc, input string tag);
        exp_t e;
        e.ac = eac; e.link = el; e.pc = epc; e.cyc = ecyc; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        start = 1'b1; start_pc = p0; ac_init = a0; link_init = l0;
        @(negedge clk);
        start = 1'b0;
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", mon_checks + drv_checks + 1,
                 mon_errors + drv_errors + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && ac == 0 && pc == 0 && !link, "R1 reset state",
            {busy, done, link}, 0);

        // R4 immediate loads
        poke(11'o100, enc(0, 0, 11'o377));
        run(11'o100, 16'o12345, 1'b1, 16'o377, 1'b1, 11'o101, 2'd1, "R4 imm load");
        poke(11'o100, enc(1, 0, 11'o1));
        run(11'o100, 16'o12345, 1'b0, 16'o177776, 1'b0, 11'o101, 2'd1, "R4 imm compl 1");
        poke(11'o100, enc(1, 0, 11'o0));
        run(11'o100, 16'o0, 1'b1, 16'o177777, 1'b1, 11'o101, 2'd1, "R4 imm compl 0");

        // R1 registers hold while idle
        repeat (5) @(negedge clk);
        chk(ac == 16'o177777 && link && pc == 11'o101, "R1 idle hold", ac, 16'o177777);

        // R6 jumps and calls, R5 auto-index
        poke(11'o100, enc(2, 0, 11'o200));
        run(11'o100, 16'o12345, 1'b1, 16'o12345, 1'b1, 11'o200, 2'd2, "R6 jmp direct");
        poke(11'o100, enc(2, 1, 11'o10)); poke(11'o10, 16'o120);
        run(11'o100, 16'o12345, 1'b0, 16'o12345, 1'b0, 11'o121, 2'd3, "R5 jmp autoindex");
        memchk(11'o10, 16'o121, "R5 pointer incremented");
        poke(11'o100, enc(2, 1, 11'o110)); poke(11'o110, 16'o120);
        run(11'o100, 16'o12345, 1'b1, 16'o12345, 1'b1, 11'o120, 2'd3, "R5 jmp plain ptr");
        memchk(11'o110, 16'o120, "R5 plain pointer kept");
        poke(11'o100, enc(3, 0, 11'o110));
        run(11'o100, 16'o1, 1'b0, 16'o1, 1'b0, 11'o111, 2'd2, "R6 call");
        memchk(11'o110, 16'o101, "R6 call return addr");

        // R7 store and exchange
        poke(11'o100, enc(4, 1, 11'o10)); poke(11'o10, 16'o120); poke(11'o121, 16'o0);
        run(11'o100, 16'o177777, 1'b1, 16'o177777, 1'b1, 11'o101, 2'd3, "R7 store ind");
        memchk(11'o121, 16'o177777, "R7 store data");
        memchk(11'o10, 16'o121, "R5 store pointer");
        poke(11'o100, enc(5, 0, 11'o110)); poke(11'o110, 16'o0);
        run(11'o100, 16'o1, 1'b0, 16'o0, 1'b0, 11'o101, 2'd2, "R7 exchange");
        memchk(11'o110, 16'o1, "R7 exchange mem");

        // R8 increment and skip
        poke(11'o100, enc(6, 0, 11'o110)); poke(11'o110, 16'o177777);
        run(11'o100, 16'o1, 1'b1, 16'o1, 1'b1, 11'o102, 2'd2, "R8 isz wraps skip");
        memchk(11'o110, 16'o0, "R8 isz zero");
        poke(11'o110, 16'o177776);
        run(11'o100, 16'o1, 1'b1, 16'o1, 1'b1, 11'o101, 2'd2, "R8 isz no skip");
        memchk(11'o110, 16'o177777, "R8 isz value");

        // R9 logic and load
        poke(11'o100, enc(7, 0, 11'o110)); poke(11'o110, 16'o52525);
        run(11'o100, 16'o177777, 1'b1, 16'o52525, 1'b1, 11'o101, 2'd2, "R9 and");
        poke(11'o100, enc(8, 1, 11'o110)); poke(11'o110, 16'o120); poke(11'o120, 16'o177000);
        run(11'o100, 16'o777, 1'b0, 16'o177777, 1'b0, 11'o101, 2'd3, "R9 or ind");
        poke(11'o100, enc(9, 0, 11'o110)); poke(11'o110, 16'o1);
        run(11'o100, 16'o177777, 1'b1, 16'o177776, 1'b1, 11'o101, 2'd2, "R9 xor");
        poke(11'o100, enc(10, 1, 11'o17)); poke(11'o17, 16'o120); poke(11'o121, 16'o54321);
        run(11'o100, 16'o1, 1'b0, 16'o54321, 1'b0, 11'o101, 2'd3, "R9 load autoindex");
        memchk(11'o17, 16'o121, "R5 window top");

        // R10 add and subtract toggle link
        poke(11'o100, enc(11, 0, 11'o110)); poke(11'o110, 16'o177777);
        run(11'o100, 16'o1, 1'b0, 16'o0, 1'b1, 11'o101, 2'd2, "R10 add carry l0");
        run(11'o100, 16'o1, 1'b1, 16'o0, 1'b0, 11'o101, 2'd2, "R10 add carry l1");
        poke(11'o110, 16'o177775);
        run(11'o100, 16'o2, 1'b1, 16'o177777, 1'b1, 11'o101, 2'd2, "R10 add no carry");
        poke(11'o100, enc(12, 0, 11'o110)); poke(11'o110, 16'o1);
        run(11'o100, 16'o0, 1'b0, 16'o177777, 1'b1, 11'o101, 2'd2, "R10 sub borrow");
        poke(11'o110, 16'o2);
        run(11'o100, 16'o2, 1'b1, 16'o0, 1'b1, 11'o101, 2'd2, "R10 sub no borrow");

        // R11 compare and skip
        poke(11'o100, enc(13, 0, 11'o110)); poke(11'o110, 16'o177776);
        run(11'o100, 16'o177776, 1'b0, 16'o177776, 1'b0, 11'o102, 2'd2, "R11 equal");
        run(11'o100, 16'o177777, 1'b1, 16'o177777, 1'b1, 11'o101, 2'd2, "R11 differ");

        // R2 unused opcode, R13 PC wrap
        poke(11'o100, enc(14, 1, 11'o110));
        run(11'o100, 16'o4321, 1'b1, 16'o4321, 1'b1, 11'o101, 2'd1, "R2 unused opcode");
        poke(11'o3777, enc(0, 0, 11'o5));
        run(11'o3777, 16'o0, 1'b0, 16'o5, 1'b0, 11'o0, 2'd1, "R13 pc wrap");

        chk(clash == 0, "R12 read write clash", clash, 0);

        $display("CHECKS %0d ERRORS %0d", mon_checks + drv_checks, mon_errors + drv_errors);
        $finish;
    end

endmodule